// File: doc/BRIEF.md
# Masked Interrupt Source Encoder

This block gathers a set of level-sensitive local-bus interrupt lines and qualifies them with a software enable mask. It presents the CPU with a single combined interrupt output and a source register. A read of the source register gives a code that identifies the lowest-numbered line that is both pending and enabled. Software reads this code, services that peripheral, and reads the register again until it returns zero.

The register file holds 16-bit registers. Offset 0x00 is the read-only source code. Offset 0x02 is the enable mask. Every other offset in the window reads as zero and ignores writes. The bus may issue byte, halfword or word accesses, and each one is mapped onto the 16-bit registers. A byte write performs a read-merge of the addressed halfword. A word access is split into two halfword accesses at the given address and at address + 2.

Reads have no side effects, so read data is presented combinationally from the current address and size. A write takes effect at the clock edge on which `bus_wr` is high. The interrupt lines are sampled into a pending register on every clock edge.

Top module: `irq_src_enc`

## Requirements
- R1: While reset is asserted and in the first cycle after it, the pending set and the mask are zero, `irq_o` is low, and a halfword read of offset 0x00 or 0x02 returns 0.
- R2: `irq_lines` is sampled on every rising clock edge. A change on a line becomes visible in the source code and in `irq_o` only after the next rising edge, not before it.
- R3: A halfword read (`bus_size` = 2'b01) of offset 0x00 returns (n+1)*4, where n is the lowest bit index set in (pending AND mask). It returns 0 when no such bit is set.
- R4: A halfword write to offset 0x02 stores `bus_wdata[15:0]` as the enable mask, and a halfword read of offset 0x02 returns it.
- R5: `irq_o` is high exactly when (pending AND mask) is nonzero.
- R6: A byte read (`bus_size` = 2'b00) returns the addressed halfword shifted right by 8 × `bus_addr[0]` in `bus_rdata[7:0]`, with bits 31:8 zero.
- R7: A byte write takes its data from `bus_wdata[7:0]`. It replaces the low byte of the addressed halfword when `bus_addr[0]` = 0 and the high byte when it is 1, and keeps the other byte.
- R8: A word read (`bus_size[1]` = 1) returns the halfword at the address in bits 15:0 and the halfword at address + 2 in bits 31:16.
- R9: A word write stores `bus_wdata[15:0]` to the halfword at the address and `bus_wdata[31:16]` to the halfword at address + 2.
- R10: Offsets other than 0x00 and 0x02 read as 0, and writes to them change nothing. Writes to the source offset 0x00 also change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_lines | input | NUM_LINES | Level interrupt requests, line 0 has the highest priority |
| bus_wr | input | 1 | Write strobe for the current access |
| bus_size | input | 2 | 00 byte, 01 halfword, 1x word |
| bus_addr | input | ADDR_W | Byte address within the register window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current address and size |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: NUM_LINES = 16 and ADDR_W = 12. With these values every line index has a distinct code from 4 to 64, every mask bit can be isolated, and the whole 4 KiB window can be swept halfword by halfword. The sweeps cover each single line and each single mask bit, suffix patterns in which lower lines must win, and a computed pseudo-random mix of lines and masks. They also exercise every size against both defined offsets, including word accesses that straddle into undefined space.

// File: rtl/irq_src_enc_pkg.sv
package irq_src_enc_pkg;
   localparam int HALF_W = 16;
   localparam int DATA_W = 32;

   typedef enum logic [1:0] {
      SZ_BYTE  = 2'b00,
      SZ_HALF  = 2'b01,
      SZ_WORD  = 2'b10,
      SZ_WORD2 = 2'b11
   } acc_size_e;

   localparam int SLOT_SRC  = 0;
   localparam int SLOT_MASK = 1;
endpackage

// File: rtl/irq_src_prio.sv
module irq_src_prio #(
   parameter int N      = 16,
   parameter int CODE_W = 16
) (
   input  logic [N-1:0]      active,
   output logic [CODE_W-1:0] code
);
   localparam int MAX_CODE = (N + 1) * 4;

   generate
      if (MAX_CODE >= (1 << CODE_W)) begin : g_bad_width
         $error("irq_src_prio: CODE_W too narrow for N");
      end
   endgenerate

   // Scan from the top so the lowest set index is the last to assign.
   always_comb begin
      code = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (active[i]) code = CODE_W'((i + 1) * 4);
      end
   end
endmodule

// File: rtl/irq_src_lanes.sv
module irq_src_lanes
   import irq_src_enc_pkg::*;
#(
   parameter int ADDR_W = 12,
   localparam int IDX_W = ADDR_W - 1
) (
   input  logic              bus_wr,
   input  logic [1:0]        bus_size,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   input  logic [HALF_W-1:0] hw_rd0,
   input  logic [HALF_W-1:0] hw_rd1,
   output logic [IDX_W-1:0]  idx0,
   output logic [IDX_W-1:0]  idx1,
   output logic              wr0_en,
   output logic [HALF_W-1:0] wr0_data,
   output logic              wr1_en,
   output logic [HALF_W-1:0] wr1_data,
   output logic [DATA_W-1:0] bus_rdata
);
   acc_size_e sz;
   logic      is_byte, is_word, hi_lane;

   assign sz      = acc_size_e'(bus_size);
   assign is_byte = (sz == SZ_BYTE);
   assign is_word = (sz == SZ_WORD) || (sz == SZ_WORD2);
   assign hi_lane = bus_addr[0];

   assign idx0 = bus_addr[ADDR_W-1:1];
   assign idx1 = idx0 + IDX_W'(1);

   // First slot: whole halfword, or a byte merged into the current value.
   always_comb begin
      wr0_en = bus_wr;
      if (is_byte) begin
         if (hi_lane) wr0_data = {bus_wdata[7:0], hw_rd0[7:0]};
         else         wr0_data = {hw_rd0[15:8], bus_wdata[7:0]};
      end else begin
         wr0_data = bus_wdata[HALF_W-1:0];
      end
   end

   // Second slot only for word accesses.
   assign wr1_en   = bus_wr && is_word;
   assign wr1_data = bus_wdata[DATA_W-1:HALF_W];

   always_comb begin
      if (is_word)      bus_rdata = {hw_rd1, hw_rd0};
      else if (is_byte) bus_rdata = {24'd0, hi_lane ? hw_rd0[15:8] : hw_rd0[7:0]};
      else              bus_rdata = {16'd0, hw_rd0};
   end
endmodule

// File: rtl/irq_src_enc.sv
module irq_src_enc
   import irq_src_enc_pkg::*;
#(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 12
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_LINES-1:0] irq_lines,
   input  logic                 bus_wr,
   input  logic [1:0]           bus_size,
   input  logic [ADDR_W-1:0]    bus_addr,
   input  logic [DATA_W-1:0]    bus_wdata,
   output logic [DATA_W-1:0]    bus_rdata,
   output logic                 irq_o
);
   localparam int IDX_W  = ADDR_W - 1;
   localparam int N_SLOT = 2;

   generate
      if (NUM_LINES < 1 || NUM_LINES > HALF_W) begin : g_bad_lines
         $error("irq_src_enc: NUM_LINES must be 1..16");
      end
      if (ADDR_W < 3) begin : g_bad_addr
         $error("irq_src_enc: ADDR_W must cover two halfwords");
      end
   endgenerate

   logic [NUM_LINES-1:0] pend_q, mask_q, active;
   logic [HALF_W-1:0]    src_code, mask_half;

   logic [IDX_W-1:0]  idx   [N_SLOT];
   logic              wr_en [N_SLOT];
   logic [HALF_W-1:0] wr_dat[N_SLOT];
   logic [HALF_W-1:0] rd_hw [N_SLOT];

   assign active = pend_q & mask_q;
   assign irq_o  = |active;

   irq_src_prio #(.N(NUM_LINES), .CODE_W(HALF_W)) u_prio (
      .active (active),
      .code   (src_code)
   );

   generate
      if (NUM_LINES < HALF_W) begin : g_pad
         assign mask_half = {{(HALF_W-NUM_LINES){1'b0}}, mask_q};
      end else begin : g_full
         assign mask_half = mask_q;
      end
   endgenerate

   // Per-slot halfword read decode.
   generate
      for (genvar k = 0; k < N_SLOT; k++) begin : g_slot
         always_comb begin
            if (idx[k] == IDX_W'(SLOT_SRC))       rd_hw[k] = src_code;
            else if (idx[k] == IDX_W'(SLOT_MASK)) rd_hw[k] = mask_half;
            else                                  rd_hw[k] = '0;
         end
      end
   endgenerate

   irq_src_lanes #(.ADDR_W(ADDR_W)) u_lanes (
      .bus_wr    (bus_wr),
      .bus_size  (bus_size),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .hw_rd0    (rd_hw[0]),
      .hw_rd1    (rd_hw[1]),
      .idx0      (idx[0]),
      .idx1      (idx[1]),
      .wr0_en    (wr_en[0]),
      .wr0_data  (wr_dat[0]),
      .wr1_en    (wr_en[1]),
      .wr1_data  (wr_dat[1]),
      .bus_rdata (bus_rdata)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= '0;
      else        pend_q <= irq_lines;
   end

   // The two slots never address the same halfword, so at most one hits.
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mask_q <= '0;
      end else if (wr_en[0] && idx[0] == IDX_W'(SLOT_MASK)) begin
         mask_q <= wr_dat[0][NUM_LINES-1:0];
      end else if (wr_en[1] && idx[1] == IDX_W'(SLOT_MASK)) begin
         mask_q <= wr_dat[1][NUM_LINES-1:0];
      end
   end
endmodule

// File: rtl/irq_src_enc_chk.sv
module irq_src_enc_chk #(
   parameter int NUM_LINES = 16,
   parameter int ADDR_W    = 12
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_LINES-1:0] irq_lines,
   input logic                 bus_wr,
   input logic [1:0]           bus_size,
   input logic [ADDR_W-1:0]    bus_addr,
   input logic [31:0]          bus_wdata,
   input logic [31:0]          bus_rdata,
   input logic                 irq_o,
   input logic [NUM_LINES-1:0] pend_q,
   input logic [NUM_LINES-1:0] mask_q
);
   logic [ADDR_W-2:0] hidx;
   logic              half_rd;
   assign hidx    = bus_addr[ADDR_W-1:1];
   assign half_rd = (bus_size == 2'b01);

   assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && mask_q == '0));

   assert_pending_sampled_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_wr |=> (irq_o == (|($past(irq_lines) & $past(mask_q)))));

   assert_src_code_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (half_rd && hidx == '0) |->
         (((pend_q & mask_q) == '0) ? (bus_rdata == 32'd0)
                                    : (bus_rdata[1:0] == 2'b00 && bus_rdata != 32'd0)));

   assert_mask_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_wr && half_rd && hidx == (ADDR_W-1)'(1)) |=>
         (mask_q == $past(bus_wdata[NUM_LINES-1:0])));

   assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (half_rd && hidx == '0) |-> (irq_o == (bus_rdata[15:0] != 16'd0)));

   assert_undef_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (half_rd && hidx > (ADDR_W-1)'(1)) |-> (bus_rdata == 32'd0));
endmodule

bind irq_src_enc irq_src_enc_chk #(.NUM_LINES(NUM_LINES), .ADDR_W(ADDR_W)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .irq_lines (irq_lines),
   .bus_wr    (bus_wr),
   .bus_size  (bus_size),
   .bus_addr  (bus_addr),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .irq_o     (irq_o),
   .pend_q    (pend_q),
   .mask_q    (mask_q)
);

// File: tb/irq_src_enc_tb.sv
module irq_src_enc_tb;
   localparam int NL = 16;
   localparam int AW = 12;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NL-1:0] irq_lines = '0;
   logic          bus_wr = 1'b0;
   logic [1:0]    bus_size = 2'b01;
   logic [AW-1:0] bus_addr = '0;
   logic [31:0]   bus_wdata = '0;
   logic [31:0]   bus_rdata;
   logic          irq_o;

   int n_cmp = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   irq_src_enc #(.NUM_LINES(NL), .ADDR_W(AW)) u_dut (
      .clk(clk), .rst_n(rst_n), .irq_lines(irq_lines), .bus_wr(bus_wr),
      .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o)
   );

   function automatic logic [15:0] exp_code(logic [15:0] act);
      logic [15:0] r = 16'd0;
      for (int i = 15; i >= 0; i--) if (act[i]) r = 16'((i + 1) * 4);
      return r;
   endfunction

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic bwrite(logic [1:0] sz, logic [AW-1:0] a, logic [31:0] d);
      @(negedge clk);
      bus_size = sz; bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(posedge clk);
      #1 bus_wr = 1'b0;
   endtask

   task automatic bread(logic [1:0] sz, logic [AW-1:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_size = sz; bus_addr = a;
      #1 d = bus_rdata;
   endtask

   task automatic set_lines(logic [NL-1:0] v);
      @(negedge clk);
      irq_lines = v;
      @(posedge clk);
      #1;
   endtask

   task automatic check_src(string req, logic [15:0] lines, logic [15:0] msk);
      logic [31:0] d;
      bread(2'b01, 12'h000, d);
      chk(req, d, {16'd0, exp_code(lines & msk)});
      chk("R5", {31'd0, irq_o}, {31'd0, |(lines & msk)});
   endtask

   initial begin
      #500000;
      if (!done) begin
         n_cmp++; n_bad++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] d;
      logic [15:0] l, m;
      irq_lines = 16'hFFFF;
      repeat (3) @(posedge clk);
      #1;
      chk("R1", {31'd0, irq_o}, 32'd0);
      @(negedge clk) rst_n = 1'b1;
      #1;
      chk("R1", {31'd0, irq_o}, 32'd0);
      bread(2'b01, 12'h002, d); chk("R1", d, 32'd0);

      // R3 single-line sweep with all lines enabled
      bwrite(2'b01, 12'h002, 32'h0000_FFFF);
      for (int i = 0; i < 16; i++) begin
         set_lines(16'(1 << i));
         check_src("R3", 16'(1 << i), 16'hFFFF);
      end
      // R3 lower line wins over every higher one
      for (int i = 0; i < 16; i++) begin
         l = 16'hFFFF << i;
         set_lines(l);
         check_src("R3", l, 16'hFFFF);
      end
      // R4 mask isolation
      set_lines(16'hFFFF);
      for (int j = 0; j < 16; j++) begin
         bwrite(2'b01, 12'h002, 32'(1 << j));
         bread(2'b01, 12'h002, d);
         chk("R4", d, 32'(1 << j));
         check_src("R3", 16'hFFFF, 16'(1 << j));
      end
      bwrite(2'b01, 12'h002, 32'h0);
      check_src("R5", 16'hFFFF, 16'h0);

      // mixed patterns
      for (int k = 0; k < 64; k++) begin
         l = 16'((k * 40503 + 12345) ^ (k << 9));
         m = 16'((k * 25173 + 13849) ^ (k << 5));
         bwrite(2'b01, 12'h002, {16'hDEAD, m});
         set_lines(l);
         check_src("R3", l, m);
      end

      // R2 timing: change visible only after the next edge
      bwrite(2'b01, 12'h002, 32'h0000_FFFF);
      set_lines(16'h0000);
      @(negedge clk);
      irq_lines = 16'h0010;
      bus_size = 2'b01; bus_addr = 12'h000;
      #1;
      chk("R2", bus_rdata, 32'd0);
      chk("R2", {31'd0, irq_o}, 32'd0);
      @(posedge clk); #1;
      chk("R2", bus_rdata, 32'd20);
      chk("R2", {31'd0, irq_o}, 32'd1);

      // R7 byte writes merge, R6 byte reads
      bwrite(2'b01, 12'h002, 32'h0000_1234);
      bwrite(2'b00, 12'h002, 32'hFFFF_FFAB);
      bread(2'b01, 12'h002, d); chk("R7", d, 32'h0000_12AB);
      bwrite(2'b00, 12'h003, 32'h0000_00CD);
      bread(2'b01, 12'h002, d); chk("R7", d, 32'h0000_CDAB);
      bread(2'b00, 12'h002, d); chk("R6", d, 32'h0000_00AB);
      bread(2'b00, 12'h003, d); chk("R6", d, 32'h0000_00CD);
      set_lines(16'h0100);
      bread(2'b00, 12'h000, d); chk("R6", d, 32'd36);
      bread(2'b00, 12'h001, d); chk("R6", d, 32'd0);

      // R9 word write at 0: upper half goes to the mask, lower half ignored
      bwrite(2'b10, 12'h000, 32'h0300_5555);
      bread(2'b01, 12'h002, d); chk("R9", d, 32'h0000_0300);
      // R8 word read at 0 and at 2
      bread(2'b10, 12'h000, d); chk("R8", d, 32'h0300_0024);
      bread(2'b11, 12'h002, d); chk("R8", d, 32'h0000_0300);
      // R9 word write at 2: low half to mask, high half to undefined space
      bwrite(2'b10, 12'h002, 32'h7777_0F0F);
      bread(2'b01, 12'h002, d); chk("R9", d, 32'h0000_0F0F);

      // R10 writes to source and undefined offsets change nothing
      bwrite(2'b01, 12'h000, 32'h0000_FFFF);
      bwrite(2'b00, 12'h001, 32'h0000_00FF);
      bwrite(2'b01, 12'h004, 32'h0000_FFFF);
      bwrite(2'b01, 12'hFFE, 32'h0000_0000);
      bwrite(2'b00, 12'h7A1, 32'h0000_0000);
      bread(2'b01, 12'h002, d); chk("R10", d, 32'h0000_0F0F);
      bread(2'b01, 12'h000, d); chk("R10", d, 32'd36);
      for (int a = 4; a < 4096; a += 2) begin
         bread(2'b01, AW'(a), d);
         if (d !== 32'd0) chk("R10", d, 32'd0);
      end
      chk("R10", 32'd0, 32'd0);
      bread(2'b10, 12'hFFE, d); chk("R10", d, 32'd36 << 16);

      // R1 reset clears state again
      @(negedge clk) rst_n = 1'b0;
      @(posedge clk); #1;
      @(negedge clk) rst_n = 1'b1;
      irq_lines = 16'h0000;
      #1;
      bread(2'b01, 12'h002, d); chk("R1", d, 32'd0);
      bread(2'b01, 12'h000, d); chk("R1", d, 32'd0);

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule